// File: doc/BRIEF.md
# Deskew Tap Calibration Controller

This block drives one channel of a programmable tapped delay line that lines a data channel up with the clock channel. It holds the channel's tap code and routes the chosen tap of the delay line to its output. The delay line is modelled here as a vector of delayed copies of the signal, one bit per tap. One reserved code routes a diagnostic bit to the output in place of any tap.

On a start request the block runs a calibration search. It starts at tap zero. For each tap it asks for a test pulse on the clock and data paths together. It then waits a programmable number of cycles for the capture to settle and reads back the captured sample. A low sample moves the search on to the next tap. The first high sample ends the search. In synchronous mode a fixed setup margin is then added to the tap that was found. If the result lies inside the legal window, it becomes the new tap code. If the result lies outside the window, or no tap ever returns a high sample, the block raises an error flag and keeps the code it held before the search. A one-cycle done pulse marks the end of every search.

Top module: `deskew_cal_ctrl`

## Requirements
- R1: After a synchronous reset, `tap_code` is 0 and `pulse_req`, `done` and `error` are all 0.
- R2: While the block is idle, `wr_en` loads `wr_code` into the tap code, which shows on `tap_code` from the next cycle. While a search runs, `wr_en` is ignored. If `start` and `wr_en` arrive in the same idle cycle, `start` wins and the write is dropped.
- R3: `sel_out` equals `tap_vec[tap_code]` for codes 0 to 13. It equals `diag_bit` for code 15 and is 0 for code 14.
- R4: A search starts at trial tap 0. While a search runs, `tap_code` shows the trial tap. `pulse_req` is high for exactly one cycle at the start of each trial.
- R5: The sample for a trial is taken `settle_cycles`+1 cycles after that trial's pulse cycle. Each trial therefore lasts `settle_cycles`+2 cycles.
- R6: A low sample advances the trial tap by one and issues a new pulse. The first high sample ends the search.
- R7: The final value is the found tap plus 3 when `sync_mode` is 1, and the found tap unchanged when `sync_mode` is 0.
- R8: A final value from 1 to 12 is loaded as the new tap code, and `error` is 0 after the search.
- R9: A final value outside 1 to 12 sets `error` and leaves the tap code as it was before the search.
- R10: If the sample at trial tap 13 is still low, the search ends with `error` set and the earlier tap code kept.
- R11: `done` is high for exactly one cycle, in the cycle the result becomes visible. `error` is cleared when a new search starts.
- R12: `start` pulses during a running search have no effect on its result or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a calibration search when idle |
| sync_mode | input | 1 | 1 adds the setup margin to the found tap |
| settle_cycles | input | SETTLE_W (4) | Extra wait cycles before each sample |
| sample_in | input | 1 | Captured channel value for the current trial |
| wr_en | input | 1 | Direct load of the tap code when idle |
| wr_code | input | TAP_W (4) | Code for a direct load |
| tap_vec | input | NUM_TAPS (14) | Delayed copies of the channel signal, one per tap |
| diag_bit | input | 1 | Diagnostic bit routed by the reserved code |
| tap_code | output | TAP_W (4) | Held code when idle, trial tap during a search |
| sel_out | output | 1 | Selected tap or diagnostic bit |
| pulse_req | output | 1 | Test pulse request, one cycle per trial |
| done | output | 1 | One-cycle end-of-search pulse |
| error | output | 1 | Last search failed, earlier code kept |

## Verification
The bench builds the block with its default parameters: 14 taps, a margin of 3 and a window of 1 to 12. At these values every edge case can be reached in a short run: a hit on tap 0, a hit on the last tap, margin overflow above 12, a zero result in asynchronous mode, and a search that never sees a high sample. The settle time is a port, so runs with 0, 1, 2 and 3 settle cycles all use the same build. Each run checks the expected search length.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_WAIT  = 2'd2
    } cal_state_e;

    typedef struct packed {
        logic       legal;
        logic [7:0] value;
    } verdict_t;

    function automatic verdict_t judge_tap(input int unsigned found,
                                           input logic        sync_en,
                                           input int unsigned margin,
                                           input int unsigned lo,
                                           input int unsigned hi);
        verdict_t    v;
        int unsigned fin;
        fin     = found + (sync_en ? margin : 0);
        v.legal = (fin >= lo) && (fin <= hi);
        v.value = fin[7:0];
        return v;
    endfunction

endpackage

// File: rtl/dsk_settle_timer.sv
module dsk_settle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R5: the wait shrinks by one each cycle until it expires
    a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/dsk_tap_mux.sv
module dsk_tap_mux #(
    parameter int NUM_TAPS  = 14,
    parameter int TAP_W     = 4,
    parameter int DIAG_CODE = 15
) (
    input  logic [TAP_W-1:0]    code,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic                diag,
    output logic                y
);
    logic [NUM_TAPS-1:0] hit;

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign hit[i] = (code == TAP_W'(i)) & taps[i];
    end

    assign y = (code == TAP_W'(DIAG_CODE)) ? diag : |hit;

endmodule

// File: rtl/dsk_search_fsm.sv
module dsk_search_fsm
    import deskew_pkg::*;
#(
    parameter int NUM_TAPS  = 14,
    parameter int TAP_W     = 4,
    parameter int MARGIN    = 3,
    parameter int MIN_FINAL = 1,
    parameter int MAX_FINAL = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sync_mode,
    input  logic             sample_in,
    input  logic             settle_zero,
    input  logic             wr_en,
    input  logic [TAP_W-1:0] wr_code,
    output logic             settle_load,
    output logic [TAP_W-1:0] tap_code,
    output logic             pulse_req,
    output logic             done,
    output logic             error
);
    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

    cal_state_e       state_q;
    logic [TAP_W-1:0] trial_q;
    logic [TAP_W-1:0] code_q;
    logic             err_q;
    logic             done_q;
    verdict_t         verdict;

    always_comb verdict = judge_tap(int'(trial_q), sync_mode, MARGIN,
                                    MIN_FINAL, MAX_FINAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            trial_q <= '0;
            code_q  <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_PULSE;
                        trial_q <= '0;
                        err_q   <= 1'b0;
                    end else if (wr_en) begin
                        code_q <= wr_code;
                    end
                end
                ST_PULSE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (settle_zero) begin
                        if (sample_in) begin
                            if (verdict.legal)
                                code_q <= TAP_W'(verdict.value);
                            else
                                err_q <= 1'b1;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (trial_q == LAST_TAP) begin
                            err_q   <= 1'b1;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            trial_q <= trial_q + 1'b1;
                            state_q <= ST_PULSE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign settle_load = (state_q == ST_PULSE);
    assign pulse_req   = (state_q == ST_PULSE);
    assign tap_code    = (state_q == ST_IDLE) ? code_q : trial_q;
    assign done        = done_q;
    assign error       = err_q;

    // R11: end-of-search pulse never lasts two cycles
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: one pulse per trial, never back to back
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (rst)
        pulse_req |=> !pulse_req);

    // R8: a clean finish leaves a code inside the window
    a_r8_commit_legal: assert property (@(posedge clk) disable iff (rst)
        (done && !error) |-> (int'(code_q) >= MIN_FINAL && int'(code_q) <= MAX_FINAL));

    // R9: a failed finish keeps the earlier code
    a_r9_hold_on_error: assert property (@(posedge clk) disable iff (rst)
        (done && error) |-> $stable(code_q));

    // R6: a pulse is always followed by waiting, not by the end of the search
    a_r6_pulse_then_wait: assert property (@(posedge clk) disable iff (rst)
        pulse_req |=> (!done && !pulse_req));

endmodule

// File: rtl/deskew_cal_ctrl.sv
module deskew_cal_ctrl #(
    parameter int NUM_TAPS  = 14,
    parameter int TAP_W     = 4,
    parameter int SETTLE_W  = 4,
    parameter int MARGIN    = 3,
    parameter int MIN_FINAL = 1,
    parameter int MAX_FINAL = 12,
    parameter int DIAG_CODE = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                sync_mode,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                sample_in,
    input  logic                wr_en,
    input  logic [TAP_W-1:0]    wr_code,
    input  logic [NUM_TAPS-1:0] tap_vec,
    input  logic                diag_bit,
    output logic [TAP_W-1:0]    tap_code,
    output logic                sel_out,
    output logic                pulse_req,
    output logic                done,
    output logic                error
);
    logic settle_load;
    logic settle_zero;

    dsk_settle_timer #(.W(SETTLE_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (settle_load),
        .load_val (settle_cycles),
        .zero     (settle_zero)
    );

    dsk_search_fsm #(
        .NUM_TAPS  (NUM_TAPS),
        .TAP_W     (TAP_W),
        .MARGIN    (MARGIN),
        .MIN_FINAL (MIN_FINAL),
        .MAX_FINAL (MAX_FINAL)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .sync_mode   (sync_mode),
        .sample_in   (sample_in),
        .settle_zero (settle_zero),
        .wr_en       (wr_en),
        .wr_code     (wr_code),
        .settle_load (settle_load),
        .tap_code    (tap_code),
        .pulse_req   (pulse_req),
        .done        (done),
        .error       (error)
    );

    dsk_tap_mux #(
        .NUM_TAPS  (NUM_TAPS),
        .TAP_W     (TAP_W),
        .DIAG_CODE (DIAG_CODE)
    ) u_mux (
        .code (tap_code),
        .taps (tap_vec),
        .diag (diag_bit),
        .y    (sel_out)
    );

endmodule

// File: tb/tb_deskew_cal_ctrl.sv
module tb_deskew_cal_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        sync_mode = 1'b0;
    logic [3:0]  settle_cycles = 4'd0;
    logic        sample_in;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_code = 4'd0;
    logic [13:0] tap_vec = 14'h2A5C;
    logic        diag_bit = 1'b0;
    logic [3:0]  tap_code;
    logic        sel_out, pulse_req, done, error;

    int thr = 99;
    int n_tests = 0;
    int n_fail  = 0;
    bit armed   = 0;

    always #4 clk = ~clk;

    assign sample_in = (int'(tap_code) >= thr);

    deskew_cal_ctrl dut (
        .clk(clk), .rst(rst), .start(start), .sync_mode(sync_mode),
        .settle_cycles(settle_cycles), .sample_in(sample_in),
        .wr_en(wr_en), .wr_code(wr_code), .tap_vec(tap_vec),
        .diag_bit(diag_bit), .tap_code(tap_code), .sel_out(sel_out),
        .pulse_req(pulse_req), .done(done), .error(error)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    bit m_busy, m_pulse, m_done, m_err;
    int m_t, m_cnt, m_code;

    always @(posedge clk) begin
        int fin;
        m_done = 0;
        if (rst) begin
            m_busy = 0; m_pulse = 0; m_err = 0; m_t = 0; m_cnt = 0; m_code = 0;
        end else if (!m_busy) begin
            if (start) begin
                m_busy = 1; m_pulse = 1; m_t = 0; m_err = 0;
            end else if (wr_en) begin
                m_code = int'(wr_code);
            end
        end else if (m_pulse) begin
            m_pulse = 0; m_cnt = int'(settle_cycles);
        end else if (m_cnt > 0) begin
            m_cnt--;
        end else if (m_t >= thr) begin
            fin = m_t + (sync_mode ? 3 : 0);
            if (fin >= 1 && fin <= 12) m_code = fin; else m_err = 1;
            m_done = 1; m_busy = 0;
        end else if (m_t == 13) begin
            m_err = 1; m_done = 1; m_busy = 0;
        end else begin
            m_t++; m_pulse = 1;
        end
        armed = 1;
    end

    function automatic int exp_sel(input int code);
        if (code == 15) return int'(diag_bit);
        if (code < 14)  return int'(tap_vec[code]);
        return 0;
    endfunction

    always @(negedge clk) begin
        int ec;
        if (armed) begin
            ec = m_busy ? m_t : m_code;
            check("R2/R4 tap_code",  int'(tap_code),  ec);
            check("R3 sel_out",      int'(sel_out),   exp_sel(ec));
            check("R4 pulse_req",    int'(pulse_req), int'(m_busy && m_pulse));
            check("R11 done",        int'(done),      int'(m_done));
            check("R9 error",        int'(error),     int'(m_err));
        end
    end

    // poke: 0 none, 1 start and write mid-search (R12, R2), 2 write with start (R2)
    task automatic run_cal(input int th, input bit sy, input int st,
                           input int exp_code, input bit exp_err,
                           input int exp_t, input int poke, input string tag);
        int n;
        @(negedge clk);
        thr = th; sync_mode = sy; settle_cycles = 4'(st);
        start = 1'b1;
        if (poke == 2) begin wr_en = 1'b1; wr_code = 4'd11; end
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0; wr_en = 1'b0;
            n++;
            if (poke == 1 && n == 3) begin
                start = 1'b1; wr_en = 1'b1; wr_code = 4'd9;
            end
        end while (!done && n < 2000);
        check({tag, " done seen (R11)"}, int'(done), 1);
        check({tag, " search length (R5)"}, n, (exp_t + 1) * (st + 2) + 1);
        check({tag, " final code"}, int'(tap_code), exp_code);
        check({tag, " error flag"}, int'(error), int'(exp_err));
        @(negedge clk);
        check({tag, " done one cycle (R11)"}, int'(done), 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 tap_code", int'(tap_code), 0);
        check("R1 pulse_req", int'(pulse_req), 0);
        check("R1 done", int'(done), 0);
        check("R1 error", int'(error), 0);

        // R6 R7: synchronous hit on tap 4 gives 7
        run_cal(4, 1, 2, 7, 0, 4, 0, "R6 R7 sync");
        // R7 R8: asynchronous keeps found tap
        run_cal(5, 0, 0, 5, 0, 5, 0, "R7 async");
        // R9: asynchronous hit on tap 0 gives 0, outside window
        run_cal(0, 0, 1, 5, 1, 0, 0, "R9 zero");
        // R9: margin pushes above 12
        run_cal(10, 1, 0, 5, 1, 10, 0, "R9 overflow");
        // R8: lowest synchronous result
        run_cal(0, 1, 3, 3, 0, 0, 0, "R8 sync low");
        // R10: no high at any tap
        run_cal(99, 1, 1, 3, 1, 13, 0, "R10 never high");
        // R8: upper edge of the window
        run_cal(12, 0, 0, 12, 0, 12, 0, "R8 upper edge");
        // R10 R9: hit only on the last tap, 13 is out of window
        run_cal(13, 0, 0, 12, 1, 13, 0, "R10 last tap");
        // R8: lower edge of the window
        run_cal(1, 0, 0, 1, 0, 1, 0, "R8 lower edge");
        // R12: start and write during the search are ignored
        run_cal(6, 0, 1, 6, 0, 6, 1, "R12 busy start");
        // R2: start wins over a write in the same cycle
        run_cal(2, 0, 0, 2, 0, 2, 2, "R2 start priority");

        // R2 R3: direct writes and selector sweep
        for (int c = 0; c < 16; c++) begin
            for (int d = 0; d < 2; d++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_code = 4'(c); diag_bit = d[0];
                tap_vec = (c % 2 == 0) ? 14'h2A5C : 14'h15A3;
                @(negedge clk);
                wr_en = 1'b0;
                check("R2 write", int'(tap_code), c);
                check("R3 select", int'(sel_out), exp_sel(c));
            end
        end

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule